// File: doc/BRIEF.md
# Image Rotator Control Registers

This block is the register front end of a frame rotation engine. A host reaches it through a simple 32-bit word bus with a request strobe, a write enable and a byte address. Writes take effect at the next clock edge, and reads return data in the same cycle. The block stores three things:

- the interrupt enables;
- a control word that packs the pixel format, the flip mode, the rotation angle and a pattern-write flag;
- the plane base addresses, buffer sizes and crop windows for both the source and the destination image.

Writing the start bit in the control word sends a one-cycle start pulse to the engine. The start bit then clears itself.

The engine reports back on two event inputs: operation finished, and illegal setting detected. Each event sets its own pending bit. Each pending bit stays set until the host writes a 1 to it. The 2-bit pending field in the status word doubles as the cause code: a value of 1 means a clean completion. The interrupt output is a level. It is high while any pending bit has its matching enable set.

Top module: `img_rot_csr`

## Requirements
- R1: After reset every readable word returns zero, irq_o is low and start_o is low.
- R2: The control word at 0x10 keeps bit 16 (pattern write), bits [10:8] (format, 1 = two-plane 4:2:0, 6 = 32-bit RGB), bits [7:6] (flip, 2 = vertical, 3 = horizontal) and bits [5:4] (rotation, 0..3 = 0/90/180/270 degrees). All other control bits read as zero once bit 0 has cleared.
- R3: A write to 0x10 with bit 0 set drives start_o high for exactly the one cycle after the write edge. Bit 0 then reads back as zero. A control write with bit 0 clear raises no pulse.
- R4: The configuration word at 0x00 keeps only bits [9:8], the enables for completion (bit 8) and illegal setting (bit 9).
- R5: Source plane addresses sit at 0x30, 0x34, 0x38 and destination plane addresses at 0x50, 0x54, 0x58. Each is a full 32-bit read/write word.
- R6: The geometry words are full 32-bit read/write words, with height or Y in bits [31:16] and width or X in bits [15:0]. They are: source buffer size 0x3C, source crop position 0x40, source crop size 0x44, destination buffer size 0x5C and destination crop position 0x60.
- R7: done_i sets status bit 8 and illegal_i sets status bit 9 on the next edge, whatever the enables hold. Status bits [9:8] = 1 therefore reads as a clean completion.
- R8: Writing 1 to status bit 8 or bit 9 clears that bit. Writing 0 leaves it unchanged.
- R9: When an engine event and a write-one-to-clear of the same bit arrive in the same cycle, the bit ends up set.
- R10: irq_o is high exactly when (status bit 8 AND enable bit 8) OR (status bit 9 AND enable bit 9).
- R11: Reads of any other word offset return zero. Writes to those offsets change no mapped word.
- R12: fmt_o, flip_o, rot_o and pattern_o follow the stored control fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address; bits [1:0] are ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle, zero when idle |
| start_o | output | 1 | One-cycle start pulse to the engine |
| fmt_o | output | 3 | Stored format code |
| flip_o | output | 2 | Stored flip code |
| rot_o | output | 2 | Stored rotation code |
| pattern_o | output | 1 | Stored pattern-write flag |
| done_i | input | 1 | Engine completion event |
| illegal_i | input | 1 | Engine illegal-setting event |
| irq_o | output | 1 | Level interrupt |

## Verification
The map is tested in two passes over all 64 word offsets: write every offset, then read every offset back. The second pass uses the bitwise inverse of the first pass's data. Each offset gets its own data, so an aliased decode or a stray write from an unmapped offset shows up as a wrong value at a mapped word. The inverted pass exposes stuck bits and missing masks.

The interrupt path is swept over every pair of enable pattern and event pattern. This separates the pending set from the enable gating.

A second sweep covers every pending pattern against every clear mask. This isolates the write-one-to-clear behaviour per bit.

Separate cases cover three timing details: an event that collides with a clear, the start pulse width, and a control write without the start bit.

// File: rtl/img_rot_csr_pkg.sv
package img_rot_csr_pkg;
  // word indices (byte offset / 4)
  localparam int CFG_IDX      = 0;
  localparam int CTRL_IDX     = 4;
  localparam int STAT_IDX     = 8;
  localparam int SRC_PLANE0   = 12;
  localparam int SRC_BSZ_IDX  = 15;
  localparam int SRC_CPOS_IDX = 16;
  localparam int SRC_CSZ_IDX  = 17;
  localparam int DST_PLANE0   = 20;
  localparam int DST_BSZ_IDX  = 23;
  localparam int DST_CPOS_IDX = 24;
  localparam int LAST_IDX     = DST_CPOS_IDX;

  localparam int GEO_N = 5;

  // events / enables live at bits [9:8] of cfg and status
  localparam int EVT_LO = 8;

  typedef struct packed {
    logic       pattern;
    logic [2:0] fmt;
    logic [1:0] flip;
    logic [1:0] rot;
  } ctrl_t;

  function automatic int geo_idx(input int k);
    case (k)
      0:       return SRC_BSZ_IDX;
      1:       return SRC_CPOS_IDX;
      2:       return SRC_CSZ_IDX;
      3:       return DST_BSZ_IDX;
      default: return DST_CPOS_IDX;
    endcase
  endfunction
endpackage

// File: rtl/img_rot_plane_bank.sv
module img_rot_plane_bank #(
  parameter int NUM_PLANES = 3,
  parameter int BASE_IDX   = 12,
  parameter int IDX_W      = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o
);
  logic [31:0] plane_q [NUM_PLANES];

  for (genvar g = 0; g < NUM_PLANES; g++) begin : g_plane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  plane_q[g] <= '0;
      else if (wr_i && int'(idx_i) == BASE_IDX + g) plane_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_PLANES; k++)
      if (int'(idx_i) == BASE_IDX + k) rdata_o = plane_q[k];
  end
endmodule

// File: rtl/img_rot_irq_unit.sv
module img_rot_irq_unit (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_we_i,
  input  logic       stat_we_i,
  input  logic [1:0] wbits_i,
  input  logic       done_i,
  input  logic       illegal_i,
  output logic [1:0] ien_o,
  output logic [1:0] pend_o,
  output logic       irq_o
);
  logic [1:0] ien_q, pend_q, clr;

  assign clr = stat_we_i ? wbits_i : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q  <= '0;
      pend_q <= '0;
    end else begin
      if (cfg_we_i) ien_q <= wbits_i;
      // set wins over a same-cycle clear
      pend_q <= (pend_q & ~clr) | {illegal_i, done_i};
    end
  end

  assign ien_o  = ien_q;
  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & ien_q);
endmodule

// File: rtl/img_rot_csr.sv
module img_rot_csr
  import img_rot_csr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_PLANES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              start_o,
  output logic [2:0]        fmt_o,
  output logic [1:0]        flip_o,
  output logic [1:0]        rot_o,
  output logic              pattern_o,
  input  logic              done_i,
  input  logic              illegal_i,
  output logic              irq_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             wr, rd;
  int               sel;
  ctrl_t            ctrl_q;
  logic             start_q;
  logic [1:0]       ien_w, pend_w;
  logic [31:0]      geo_q [GEO_N];
  logic [31:0]      src_rd, dst_rd;

  assign idx = addr_i[ADDR_W-1:2];
  assign sel = int'(idx);
  assign wr  = req_i && we_i;
  assign rd  = req_i && !we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= wr && sel == CTRL_IDX && wdata_i[0];
      if (wr && sel == CTRL_IDX)
        ctrl_q <= '{pattern: wdata_i[16], fmt: wdata_i[10:8],
                    flip: wdata_i[7:6], rot: wdata_i[5:4]};
    end
  end

  for (genvar g = 0; g < GEO_N; g++) begin : g_geo
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         geo_q[g] <= '0;
      else if (wr && sel == geo_idx(g))    geo_q[g] <= wdata_i;
    end
  end

  img_rot_plane_bank #(.NUM_PLANES(NUM_PLANES), .BASE_IDX(SRC_PLANE0), .IDX_W(IDX_W)) u_src (
    .clk_i, .rst_ni, .wr_i(wr), .idx_i(idx), .wdata_i, .rdata_o(src_rd));

  img_rot_plane_bank #(.NUM_PLANES(NUM_PLANES), .BASE_IDX(DST_PLANE0), .IDX_W(IDX_W)) u_dst (
    .clk_i, .rst_ni, .wr_i(wr), .idx_i(idx), .wdata_i, .rdata_o(dst_rd));

  img_rot_irq_unit u_irq (
    .clk_i, .rst_ni,
    .cfg_we_i (wr && sel == CFG_IDX),
    .stat_we_i(wr && sel == STAT_IDX),
    .wbits_i  (wdata_i[EVT_LO+1:EVT_LO]),
    .done_i, .illegal_i,
    .ien_o (ien_w),
    .pend_o(pend_w),
    .irq_o);

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (sel)
        CFG_IDX:  rdata_o = {22'd0, ien_w, 8'd0};
        CTRL_IDX: rdata_o = {15'd0, ctrl_q.pattern, 5'd0, ctrl_q.fmt,
                             ctrl_q.flip, ctrl_q.rot, 3'd0, start_q};
        STAT_IDX: rdata_o = {22'd0, pend_w, 8'd0};
        default:  rdata_o = src_rd | dst_rd;
      endcase
      for (int k = 0; k < GEO_N; k++)
        if (sel == geo_idx(k)) rdata_o = geo_q[k];
    end
  end

  assign start_o   = start_q;
  assign fmt_o     = ctrl_q.fmt;
  assign flip_o    = ctrl_q.flip;
  assign rot_o     = ctrl_q.rot;
  assign pattern_o = ctrl_q.pattern;
endmodule

// File: rtl/img_rot_csr_chk.sv
module img_rot_csr_chk
  import img_rot_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              start_o,
  input logic              done_i,
  input logic              illegal_i,
  input logic              irq_o,
  input logic [1:0]        ien_i,
  input logic [1:0]        pend_i
);
  logic ctrl_start_wr, stat_clr0, stat_clr1, far_rd;
  assign ctrl_start_wr = req_i && we_i && int'(addr_i[ADDR_W-1:2]) == CTRL_IDX && wdata_i[0];
  assign stat_clr0 = req_i && we_i && int'(addr_i[ADDR_W-1:2]) == STAT_IDX && wdata_i[8];
  assign stat_clr1 = req_i && we_i && int'(addr_i[ADDR_W-1:2]) == STAT_IDX && wdata_i[9];
  assign far_rd    = req_i && !we_i && int'(addr_i[ADDR_W-1:2]) > LAST_IDX;

  AST_START_PULSE:  assert property (@(posedge clk_i) disable iff (!rst_ni) start_o |=> !start_o); // R3
  AST_START_CAUSE:  assert property (@(posedge clk_i) disable iff (!rst_ni) ctrl_start_wr |=> start_o); // R3
  AST_DONE_SETS:    assert property (@(posedge clk_i) disable iff (!rst_ni) done_i |=> pend_i[0]); // R7
  AST_ILLEGAL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni) illegal_i |=> pend_i[1]); // R7
  AST_DONE_STICKY:  assert property (@(posedge clk_i) disable iff (!rst_ni) pend_i[0] && !stat_clr0 |=> pend_i[0]); // R8
  AST_ILL_STICKY:   assert property (@(posedge clk_i) disable iff (!rst_ni) pend_i[1] && !stat_clr1 |=> pend_i[1]); // R8
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni) ien_i == 2'b00 |-> !irq_o); // R10
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni) irq_o |-> pend_i != 2'b00); // R10
  AST_FAR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) far_rd |-> rdata_o == 32'd0); // R11
endmodule

bind img_rot_csr img_rot_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .start_o,
  .done_i, .illegal_i, .irq_o, .ien_i(ien_w), .pend_i(pend_w));

// File: tb/sim_img_rot_csr.sv
`timescale 1ns/1ps
module sim_img_rot_csr;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        start_o, pattern_o, done_i = 1'b0, illegal_i = 1'b0, irq_o;
  logic [2:0]  fmt_o;
  logic [1:0]  flip_o, rot_o;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  img_rot_csr u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i); req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); req_i = 0; we_i = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i); req_i = 1; we_i = 0; addr_i = a;
    #1 d = rdata_o;
    req_i = 0;
  endtask

  task automatic pulse(input logic dn, input logic il);
    @(negedge clk_i); done_i = dn; illegal_i = il;
    @(negedge clk_i); done_i = 0; illegal_i = 0;
  endtask

  function automatic logic [31:0] keep_mask(input int w);
    case (w)
      0:                          return 32'h0000_0300;
      4:                          return 32'h0001_07F0;
      12, 13, 14, 20, 21, 22:     return 32'hFFFF_FFFF;
      15, 16, 17, 23, 24:         return 32'hFFFF_FFFF;
      default:                    return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input int w);
    case (w)
      0:                      return "R4";
      4:                      return "R2";
      12, 13, 14, 20, 21, 22: return "R5";
      15, 16, 17, 23, 24:     return "R6";
      default:                return "R11";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R1 reset state
    for (int w = 0; w < 64; w++) begin
      rd(8'(w * 4), d);
      chk("R1 reset read", d, 32'h0);
    end
    chk("R1 irq", {31'd0, irq_o}, 32'h0);
    chk("R1 start", {31'd0, start_o}, 32'h0);

    // map sweep, direct then inverted data
    for (int p = 0; p < 2; p++) begin
      for (int w = 0; w < 64; w++)
        wr(8'(w * 4), (32'h9E37_79B9 * (w + 1)) ^ (p != 0 ? 32'hFFFF_FFFF : 32'h0));
      for (int w = 0; w < 64; w++) begin
        rd(8'(w * 4), d);
        chk(tag_of(w), d, ((32'h9E37_79B9 * (w + 1)) ^ (p != 0 ? 32'hFFFF_FFFF : 32'h0)) & keep_mask(w));
      end
    end
    wr(8'h00, 32'h0);
    wr(8'h20, 32'h300);

    // R12 field outputs
    wr(8'h10, 32'h0001_06E0);
    chk("R12 fmt", {29'd0, fmt_o}, 32'd6);
    chk("R12 flip", {30'd0, flip_o}, 32'd3);
    chk("R12 rot", {30'd0, rot_o}, 32'd2);
    chk("R12 pattern", {31'd0, pattern_o}, 32'd1);
    wr(8'h10, 32'h0000_0150);
    chk("R12 fmt2", {29'd0, fmt_o}, 32'd1);
    chk("R12 flip2", {30'd0, flip_o}, 32'd1);
    chk("R12 rot2", {30'd0, rot_o}, 32'd1);
    chk("R12 pattern2", {31'd0, pattern_o}, 32'd0);

    // R3 start pulse
    wr(8'h10, 32'h0000_0191);
    chk("R3 start high", {31'd0, start_o}, 32'd1);
    @(negedge clk_i);
    chk("R3 start low", {31'd0, start_o}, 32'd0);
    rd(8'h10, d);
    chk("R3 bit0 cleared", d, 32'h0000_0190);
    wr(8'h10, 32'h0000_0190);
    chk("R3 no pulse", {31'd0, start_o}, 32'd0);
    @(negedge clk_i);
    chk("R3 no pulse later", {31'd0, start_o}, 32'd0);

    // R7 / R10 sweep of enables against events
    for (int en = 0; en < 4; en++)
      for (int ev = 0; ev < 4; ev++) begin
        wr(8'h20, 32'h300);
        wr(8'h00, 32'(en) << 8);
        pulse(ev[0], ev[1]);
        rd(8'h20, d);
        chk("R7 pending", d, 32'(ev) << 8);
        chk("R10 irq", {31'd0, irq_o}, {31'd0, |(en[1:0] & ev[1:0])});
      end

    // R8 clear sweep
    wr(8'h00, 32'h0);
    for (int pd = 0; pd < 4; pd++)
      for (int cl = 0; cl < 4; cl++) begin
        wr(8'h20, 32'h300);
        pulse(pd[0], pd[1]);
        wr(8'h20, 32'hFFFF_FCFF | (32'(cl) << 8));
        rd(8'h20, d);
        chk("R8 w1c", d, 32'((pd & ~cl) & 3) << 8);
      end

    // R9 set beats clear
    wr(8'h20, 32'h300);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = 8'h20; wdata_i = 32'h300; done_i = 1;
    @(negedge clk_i);
    req_i = 0; we_i = 0; done_i = 0;
    rd(8'h20, d);
    chk("R9 done vs clear", d, 32'h100);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = 8'h20; wdata_i = 32'h300; illegal_i = 1;
    @(negedge clk_i);
    req_i = 0; we_i = 0; illegal_i = 0;
    rd(8'h20, d);
    chk("R9 illegal vs clear", d, 32'h200);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule